// File: doc/BRIEF.md
# Parallel Lifting Wavelet Stage

This block performs one level of a one-dimensional integer 5/3 wavelet split along an image row. It takes ten pixels at a time. Every valid cycle delivers one word of ten samples, and flags mark the first and last word of a row. Each word is split into five even-position and five odd-position samples. All five high-pass (detail) and five low-pass (approximation) coefficients of the word are computed in the same cycle.

Some samples needed by a word lie in the word before it or the word after it. The stage therefore keeps the last two samples of the previous word in registers. It holds the current word until the first sample of the next word is on the input. Outputs thus trail the input by one word. At the two ends of a row the missing samples are mirrored from inside the row. The approximation coefficients are packed two groups per output word, so an identical stage (built with signed inputs two bits wider) can follow this one with no gaps. The stage never stalls.

Top module: `lift53_stage`

## Requirements
- R1: After reset, `detValid` and `apxValid` are low and stay low until a word has been accepted.
- R2: For every odd row position n, the detail coefficient is x[n] − floor((x[n−1] + x[n+1]) / 2).
- R3: For every even row position n, the approximation is floor((6·x[n] + 2·x[n−1] + 2·x[n+1] − x[n−2] − x[n+2]) / 8).
- R4: Neighbours outside the current word come from the adjacent words of the same row: the last two samples of the previous word and the first sample of the next word.
- R5: On the first word of a row, x[−1] is taken as x[1] and x[−2] as x[2].
- R6: On the last word of a row of N samples, x[N] is taken as x[N−2].
- R7: A word that does not end its row has its results shown for one cycle, starting right after the clock edge that accepts the next word. A word that ends its row has its results shown right after the edge that follows its own acceptance edge.
- R8: Approximation groups are packed in pairs. The earlier group fills lanes 0–4 (low bits) and the later group fills lanes 5–9. `apxValid` rises together with `detValid` of the later word of each pair.
- R9: If a row has an odd number of words, its last group goes out alone in lanes 0–4, with lanes 5–9 all zero. Pairing starts over at each row.
- R10: A word can be accepted on every cycle, including a row's first word directly after the previous row's last word, and no results are lost.
- R11: Inputs are unsigned 10-bit samples, with lane k at bits [10k+9:10k] and sample 0 first in the row. Outputs are two's-complement 12-bit values, with lane i at bits [12i+11:12i].
- R12: Idle cycles between the words of a row do not change any coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word present this cycle |
| inSor | input | 1 | Input word is the first of a row |
| inEor | input | 1 | Input word is the last of a row |
| inWord | input | 100 | Ten 10-bit samples, lane 0 lowest |
| detValid | output | 1 | Detail word valid |
| detWord | output | 60 | Five signed 12-bit detail coefficients |
| apxValid | output | 1 | Packed approximation word valid |
| apxWord | output | 120 | Ten signed 12-bit approximation coefficients |

## Verification
A word that is not the last of its row yields its detail word on the cycle after the edge that accepts its successor. The last word of a row yields its detail word one edge after its own acceptance edge. A packed approximation word arrives in the same cycle as the detail word of the word that closes its pair. The bench records the edge at which each word is taken and stamps every captured output with the edge count. It compares both the values and the stamps against a model that computes them with mirrored indices. Rows are driven back to back, with gaps, as a single word, and in odd and even word counts, so that each latency case and each packing case occurs.

// File: rtl/lift53_pkg.sv
package lift53_pkg;

  // Strobes from the sequencing logic to the datapath.
  typedef struct packed {
    logic load;       // capture the incoming word as the held word
    logic emit;       // compute and register results of the held word
    logic leftEdge;   // held word opens its row: mirror left neighbours
    logic rightEdge;  // held word closes its row: mirror right neighbour
    logic keepLow;    // store this group as the low half of a pair
    logic packOut;    // drive a packed approximation word
    logic pairHigh;   // a low half is waiting
  } lift_strobe_t;

endpackage

// File: rtl/lift53_ctrl.sv
module lift53_ctrl
  import lift53_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         inSor,
  input  logic         inEor,
  output lift_strobe_t st,
  output logic         detValid,
  output logic         apxValid
);

  logic pendValid, pendSor, pendEor, half;
  logic emit;

  assign emit = pendValid & (pendEor | inValid);

  always_comb begin
    st.load      = inValid;
    st.emit      = emit;
    st.leftEdge  = pendSor;
    st.rightEdge = pendEor;
    st.keepLow   = emit & ~half & ~pendEor;
    st.packOut   = emit & (half | pendEor);
    st.pairHigh  = half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendValid <= 1'b0;
      pendSor   <= 1'b0;
      pendEor   <= 1'b0;
      half      <= 1'b0;
      detValid  <= 1'b0;
      apxValid  <= 1'b0;
    end else begin
      pendValid <= inValid | (pendValid & ~emit);
      if (inValid) begin
        pendSor <= inSor;
        pendEor <= inEor;
      end
      if (emit) half <= pendEor ? 1'b0 : ~half;
      detValid <= emit;
      apxValid <= emit & (half | pendEor);
    end
  end

  // R8: a packed word only ever comes with a detail word
  p_apx_with_det_r8: assert property (@(posedge clk) disable iff (!rst_n)
    apxValid |-> detValid);

  // R7: the last word of a row is flushed two edges after it is offered
  p_eor_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inEor) |=> ##1 detValid);

  // R9: every row end produces a packed word (pair or lone group)
  p_eor_pack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inEor) |=> ##1 apxValid);

  // R10: a word that does not open a row must continue an open row
  p_row_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !inSor) |-> (pendValid && !pendEor));

endmodule

// File: rtl/lift53_dp.sv
module lift53_dp
  import lift53_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int LANES     = 10,
  parameter int SIGNED_IN = 0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  lift_strobe_t                        st,
  input  logic [LANES*SAMPLE_W-1:0]           inWord,
  output logic [(LANES/2)*(SAMPLE_W+2)-1:0]   detWord,
  output logic [LANES*(SAMPLE_W+2)-1:0]       apxWord
);

  localparam int HALF = LANES / 2;
  localparam int OW   = SAMPLE_W + 2;
  localparam int CW   = SAMPLE_W + 5;
  localparam int EXT  = LANES + 3;

  logic [LANES*SAMPLE_W-1:0] pendWord;
  logic [SAMPLE_W-1:0]       prevA, prevB;   // previous word, lanes LANES-2 and LANES-1
  logic [HALF*OW-1:0]        lowGrp;
  logic [HALF*OW-1:0]        detNext, apxGrp;
  logic signed [CW-1:0]      ext [EXT];      // ext[k] holds row sample (base + k - 2)

  function automatic logic signed [CW-1:0] widen(input logic [SAMPLE_W-1:0] s);
    if (SIGNED_IN != 0) widen = CW'($signed(s));
    else                widen = CW'(s);
  endfunction

  always_comb begin
    for (int k = 0; k < LANES; k++) ext[k+2] = widen(pendWord[k*SAMPLE_W +: SAMPLE_W]);
    ext[0]     = st.leftEdge  ? widen(pendWord[2*SAMPLE_W +: SAMPLE_W]) : widen(prevA);
    ext[1]     = st.leftEdge  ? widen(pendWord[SAMPLE_W +: SAMPLE_W])   : widen(prevB);
    ext[EXT-1] = st.rightEdge ? widen(pendWord[(LANES-2)*SAMPLE_W +: SAMPLE_W])
                              : widen(inWord[0 +: SAMPLE_W]);
  end

  for (genvar g = 0; g < HALF; g++) begin : g_lane
    logic signed [CW-1:0] evenSum, oddSum, outSum, center;
    logic signed [OW-1:0] dVal, aVal;
    assign evenSum = ext[2*g+2] + ext[2*g+4];
    assign oddSum  = ext[2*g+1] + ext[2*g+3];
    assign outSum  = ext[2*g]   + ext[2*g+4];
    assign center  = (ext[2*g+2] <<< 2) + (ext[2*g+2] <<< 1);
    assign dVal    = OW'(ext[2*g+3] - (evenSum >>> 1));
    assign aVal    = OW'((center + (oddSum <<< 1) - outSum) >>> 3);
    assign detNext[g*OW +: OW] = dVal;
    assign apxGrp[g*OW +: OW]  = aVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendWord <= '0;
      prevA    <= '0;
      prevB    <= '0;
      lowGrp   <= '0;
      detWord  <= '0;
      apxWord  <= '0;
    end else begin
      if (st.load) pendWord <= inWord;
      if (st.emit) begin
        prevA   <= pendWord[(LANES-2)*SAMPLE_W +: SAMPLE_W];
        prevB   <= pendWord[(LANES-1)*SAMPLE_W +: SAMPLE_W];
        detWord <= detNext;
        if (st.keepLow) lowGrp <= apxGrp;
        if (st.packOut)
          apxWord <= st.pairHigh ? {apxGrp, lowGrp} : {{(HALF*OW){1'b0}}, apxGrp};
      end
    end
  end

  // R12: the held word changes only when a new word is taken
  p_hold_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !st.load |=> $stable(pendWord));

endmodule

// File: rtl/lift53_stage.sv
module lift53_stage
  import lift53_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int LANES     = 10,
  parameter int SIGNED_IN = 0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              inValid,
  input  logic                              inSor,
  input  logic                              inEor,
  input  logic [LANES*SAMPLE_W-1:0]         inWord,
  output logic                              detValid,
  output logic [(LANES/2)*(SAMPLE_W+2)-1:0] detWord,
  output logic                              apxValid,
  output logic [LANES*(SAMPLE_W+2)-1:0]     apxWord
);

  lift_strobe_t st;

  lift53_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inSor    (inSor),
    .inEor    (inEor),
    .st       (st),
    .detValid (detValid),
    .apxValid (apxValid)
  );

  lift53_dp #(
    .SAMPLE_W  (SAMPLE_W),
    .LANES     (LANES),
    .SIGNED_IN (SIGNED_IN)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .inWord  (inWord),
    .detWord (detWord),
    .apxWord (apxWord)
  );

endmodule

// File: tb/lift53_stage_bench.sv
module lift53_stage_bench;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         inSor = 1'b0;
  logic         inEor = 1'b0;
  logic [99:0]  inWord = '0;
  logic         detValid;
  logic [59:0]  detWord;
  logic         apxValid;
  logic [119:0] apxWord;

  lift53_stage u_lift53_stage (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSor(inSor), .inEor(inEor),
    .inWord(inWord), .detValid(detValid), .detWord(detWord),
    .apxValid(apxValid), .apxWord(apxWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // stimulus description
  int px [0:199];
  int nW;
  bit rowS [0:19];
  bit rowE [0:19];
  int gapB [0:19];
  int acc  [0:19];
  int seed = 7;

  // captured outputs
  logic [59:0]  capDet [0:31];
  int           capDetCyc [0:31];
  int           nDet = 0;
  logic [119:0] capApx [0:31];
  int           capApxCyc [0:31];
  int           nApx = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (detValid && nDet < 32) begin
        capDet[nDet] = detWord; capDetCyc[nDet] = cyc; nDet = nDet + 1;
      end
      if (apxValid && nApx < 32) begin
        capApx[nApx] = apxWord; capApxCyc[nApx] = cyc; nApx = nApx + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, act=%0d exp=<50000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [119:0] act, input logic [119:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 1023;
  endfunction

  // row-local sample with symmetric mirroring
  function automatic int xAt(int base, int len, int n);
    int m = n;
    if (m < 0) m = -m;
    if (m >= len) m = 2 * (len - 1) - m;
    return px[base + m];
  endfunction

  task automatic playAndCheck(input string scen);
    logic [59:0]  expDet, expGrp, prevGrp;
    logic [119:0] expApx;
    int ai, rsW, reW, len, base, off, stamp;
    nDet = 0; nApx = 0;
    for (int w = 0; w < nW; w++) begin
      for (int g = 0; g < gapB[w]; g++) begin
        @(negedge clk); inValid = 1'b0;
      end
      @(negedge clk);
      inValid = 1'b1; inSor = rowS[w]; inEor = rowE[w];
      for (int k = 0; k < 10; k++) inWord[k*10 +: 10] = 10'(px[10*w + k]);
      acc[w] = cyc + 1;
    end
    @(negedge clk); inValid = 1'b0; inSor = 1'b0; inEor = 1'b0;
    repeat (6) @(negedge clk);

    chk(nDet == nW, {"R7 detail word count ", scen}, 120'(nDet), 120'(nW));
    ai = 0; prevGrp = '0; rsW = 0;
    for (int w = 0; w < nW && w < nDet; w++) begin
      if (rowS[w]) rsW = w;
      reW = w;
      while (!rowE[reW]) reW = reW + 1;
      len  = 10 * (reW - rsW + 1);
      base = 10 * rsW;
      off  = 10 * (w - rsW);
      for (int i = 0; i < 5; i++) begin
        int n = off + 2 * i;
        int d = xAt(base, len, n+1) - ((xAt(base, len, n) + xAt(base, len, n+2)) >>> 1);
        int a = (6 * xAt(base, len, n) + 2 * (xAt(base, len, n-1) + xAt(base, len, n+1))
                 - xAt(base, len, n-2) - xAt(base, len, n+2)) >>> 3;
        expDet[i*12 +: 12] = 12'(d);
        expGrp[i*12 +: 12] = 12'(a);
      end
      stamp = rowE[w] ? acc[w] + 1 : acc[w+1];
      chk(capDet[w] == expDet, {"R2 R4 R11 detail value ", scen}, 120'(capDet[w]), 120'(expDet));
      chk(capDetCyc[w] == stamp, {"R7 detail timing ", scen}, 120'(capDetCyc[w]), 120'(stamp));
      if (((w - rsW) % 2) == 1 || rowE[w]) begin
        expApx = (((w - rsW) % 2) == 1) ? {expGrp, prevGrp} : {60'b0, expGrp};
        if (ai < nApx) begin
          chk(capApx[ai] == expApx, {"R3 R8 R9 packed value ", scen}, capApx[ai], expApx);
          chk(capApxCyc[ai] == stamp, {"R8 packed timing ", scen}, 120'(capApxCyc[ai]), 120'(stamp));
        end
        ai = ai + 1;
      end
      prevGrp = expGrp;
    end
    chk(nApx == ai, {"R8 R9 packed word count ", scen}, 120'(nApx), 120'(ai));
  endtask

  task automatic setRow(input int first, input int words);
    for (int w = first; w < first + words; w++) begin
      rowS[w] = (w == first);
      rowE[w] = (w == first + words - 1);
      gapB[w] = 0;
    end
  endtask

  task automatic tReset();
    chk(detValid == 1'b0, "R1 detValid after reset", 120'(detValid), 120'(0));
    chk(apxValid == 1'b0, "R1 apxValid after reset", 120'(apxValid), 120'(0));
    repeat (3) @(negedge clk);
    chk(detValid == 1'b0 && apxValid == 1'b0, "R1 idle outputs", 120'({detValid, apxValid}), 120'(0));
  endtask

  task automatic tRamp();
    nW = 4; setRow(0, 4);
    for (int i = 0; i < 40; i++) px[i] = (i * 37 + 5) % 1024;
    playAndCheck("R4 R8 R10 ramp");
  endtask

  task automatic tExtreme();
    nW = 3; setRow(0, 3);
    for (int i = 0; i < 30; i++) px[i] = (i < 14) ? (((i % 2) == 0) ? 1023 : 0)
                                                   : (((i % 2) == 0) ? 0 : 1023);
    playAndCheck("R9 R11 extremes");
  endtask

  task automatic tSingle();
    nW = 1; setRow(0, 1);
    for (int i = 0; i < 10; i++) px[i] = nextRand();
    playAndCheck("R5 R6 R9 single word");
  endtask

  task automatic tGaps();
    nW = 3; setRow(0, 3);
    gapB[1] = 3; gapB[2] = 2;
    for (int i = 0; i < 30; i++) px[i] = nextRand();
    playAndCheck("R12 gaps");
  endtask

  task automatic tTwoRows();
    nW = 5; setRow(0, 3); setRow(3, 2);
    for (int i = 0; i < 50; i++) px[i] = nextRand();
    playAndCheck("R5 R6 R9 R10 back to back rows");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tRamp();
    tExtreme();
    tSingle();
    tGaps();
    tTwoRows();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule